// File: doc/BRIEF.md
# Dual-Channel Serial Converter Update Sequencer

This block sits on the controller side of a serial link to a dual-channel 12-bit digital-to-analog converter. A single start command takes a 12-bit code and a two-bit active-low channel mask. The sequencer lowers the chip select and sends a 16-bit frame, most significant bit first. The frame is four zero padding bits followed by the code. It then strobes the load line of every channel whose mask bit is zero and releases the chip select. Because the load phase is separate from the shift phase, one shifted value can update channel A, channel B or both at once.

A second command issues a converter reset. The sequencer first drives the preset-select line to the requested level, then pulses the reset line low. Every timed phase lasts `HALF_CYC` system clocks. `HALF_CYC` is the larger of the 40 ns and 15 ns interface minimums divided by `CLK_PERIOD_NS` and rounded up, which is 4 at the default 10 ns period. Serial clock high time, serial clock low time, chip-select setup, chip-select hold and load width therefore all meet their minimums with margin. The block reports `busy` for as long as it is working and gives a one-cycle `done` pulse when it finishes.

Top module: `dac_update_seq`

## Requirements
- R1: After reset: `csN`=1, `ldN`=2'b11, `rstOutN`=1, `sclk`=0, `sdata`=0, `presetSel`=0, `busy`=0, `done`=0.
- R2: A frame has exactly 16 rising `sclk` edges while `csN` is low. The bits sampled on those edges are four zeros, then `codeIn[11]` down to `codeIn[0]`.
- R3: `sdata` changes only while `sclk` is low, and each `sclk` high phase and low phase lasts at least `HALF_CYC` clocks.
- R4: `csN` is low for at least `HALF_CYC` clocks before the first rising `sclk` edge. It stays low through the frame and the load phase, and `sclk` is high only while `csN` is low.
- R5: After the 16th bit, `ldN[0]` (channel A) pulses low once if mask bit 0 is 0, and `ldN[1]` (channel B) pulses low once if mask bit 1 is 0. The pulses are simultaneous when both bits are 0 and last at least `HALF_CYC` clocks. A mask bit of 1 gives no pulse on that channel.
- R6: A load line is low only while `sclk` is low. Once all load lines are high again, `csN` stays low for at least `HALF_CYC` more clocks before it rises.
- R7: `busy` is high from the clock after an accepted command through the `done` cycle, and low otherwise. `done` is a one-cycle pulse, issued with `csN` high and `ldN`=2'b11. While idle, `csN`, `rstOutN` and both load lines are high.
- R8: Start and reset commands that arrive while `busy` is high are ignored. They do not change the frame in flight and start no later operation.
- R9: A reset command sets `presetSel` to `presetHigh` at least `HALF_CYC` clocks before `rstOutN` falls. `rstOutN` is then low for at least `HALF_CYC` clocks while `presetSel` holds steady. `csN` and `sclk` stay inactive, and `presetSel` keeps its level afterwards.
- R10: When start and reset are requested in the same idle cycle, the frame is sent and no reset pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a frame and load sequence (taken when idle) |
| codeIn | input | 12 | Code to send |
| chanMaskN | input | 2 | Active-low channel select: bit 0 channel A, bit 1 channel B |
| resetReq | input | 1 | Issue a converter reset pulse (taken when idle) |
| presetHigh | input | 1 | Preset level to drive during a reset command |
| sclk | output | 1 | Serial clock to the converter |
| sdata | output | 1 | Serial data, changed while sclk is low |
| csN | output | 1 | Active-low chip select |
| ldN | output | 2 | Active-low load strobes, bit 0 channel A, bit 1 channel B |
| rstOutN | output | 1 | Active-low converter reset |
| presetSel | output | 1 | Preset-select level for the converter |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions watch the protocol on every cycle. They check that the serial clock runs only under chip select and that data holds while the clock is high. They also check that load strobes fall only in a clock-low window, that the reset pulse and the frame never overlap, that preset select is steady under reset, that the lines are quiet while idle, and that `done` lasts one cycle. Other properties depend on whole sequences, and only the bench scenarios show them. These are the bit order and zero padding of the frame, the exact set of channels strobed for each mask, the phase widths in clocks, the chip-select lead and tail, the rejection of commands while busy, and start taking priority over reset.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CS_SETUP,
    ST_CLK_HI,
    ST_CLK_LO,
    ST_LOAD,
    ST_LOAD_REC,
    ST_RST_SETUP,
    ST_RST_LOW,
    ST_RST_REC,
    ST_FINISH
  } seqState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic latchPreset;
    logic ldPhase;
  } dpCtl_t;

  function automatic int unsigned ceilDiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned FRAME_W  = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   startReq,
  input  logic   resetReq,
  output dpCtl_t dpCtl,
  output logic   sclk,
  output logic   csN,
  output logic   rstOutN,
  output logic   busy,
  output logic   done
);

  localparam int unsigned TMR_W = $clog2(HALF_CYC + 1);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

  seqState_e   state, stateNext;
  logic [TMR_W-1:0] phaseTmr;
  logic [CNT_W-1:0] bitCnt;
  logic        phaseEnd;
  logic        sclkQ, csNQ, rstNQ, busyQ, doneQ, ldPhaseQ;
  logic        loadFrame, shiftBit, latchPreset;

  assign phaseEnd = (phaseTmr == '0);

  always_comb begin
    stateNext   = state;
    loadFrame   = 1'b0;
    shiftBit    = 1'b0;
    latchPreset = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNext = ST_CS_SETUP;
          loadFrame = 1'b1;
        end else if (resetReq) begin
          stateNext   = ST_RST_SETUP;
          latchPreset = 1'b1;
        end
      end
      ST_CS_SETUP:  if (phaseEnd) stateNext = ST_CLK_HI;
      ST_CLK_HI: begin
        if (phaseEnd) begin
          stateNext = ST_CLK_LO;
          shiftBit  = 1'b1;
        end
      end
      ST_CLK_LO: begin
        if (phaseEnd)
          stateNext = (bitCnt == CNT_W'(FRAME_W)) ? ST_LOAD : ST_CLK_HI;
      end
      ST_LOAD:      if (phaseEnd) stateNext = ST_LOAD_REC;
      ST_LOAD_REC:  if (phaseEnd) stateNext = ST_FINISH;
      ST_RST_SETUP: if (phaseEnd) stateNext = ST_RST_LOW;
      ST_RST_LOW:   if (phaseEnd) stateNext = ST_RST_REC;
      ST_RST_REC:   if (phaseEnd) stateNext = ST_FINISH;
      ST_FINISH:    stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phaseTmr <= '0;
      bitCnt   <= '0;
      sclkQ    <= 1'b0;
      csNQ     <= 1'b1;
      rstNQ    <= 1'b1;
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
      ldPhaseQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (stateNext != state)
        phaseTmr <= TMR_W'(HALF_CYC - 1);
      else if (!phaseEnd)
        phaseTmr <= phaseTmr - 1'b1;
      if (state == ST_IDLE)
        bitCnt <= '0;
      else if (shiftBit)
        bitCnt <= bitCnt + 1'b1;
      // pin levels registered from the next state: no decode glitches
      sclkQ    <= (stateNext == ST_CLK_HI);
      csNQ     <= !(stateNext inside {ST_CS_SETUP, ST_CLK_HI, ST_CLK_LO,
                                      ST_LOAD, ST_LOAD_REC});
      rstNQ    <= (stateNext != ST_RST_LOW);
      busyQ    <= (stateNext != ST_IDLE);
      doneQ    <= (stateNext == ST_FINISH);
      ldPhaseQ <= (stateNext == ST_LOAD);
    end
  end

  always_comb begin
    dpCtl.loadFrame   = loadFrame;
    dpCtl.shiftBit    = shiftBit;
    dpCtl.latchPreset = latchPreset;
    dpCtl.ldPhase     = ldPhaseQ;
  end

  assign sclk    = sclkQ;
  assign csN     = csNQ;
  assign rstOutN = rstNQ;
  assign busy    = busyQ;
  assign done    = doneQ;

  // R4
  sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclkQ |-> !csNQ);

  // R6
  ld_in_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ldPhaseQ |-> (!sclkQ && !csNQ));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ |=> !doneQ);

  // R9
  rst_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rstNQ |-> (csNQ && !sclkQ));

endmodule

// File: rtl/dac_seq_dp.sv
module dac_seq_dp
  import dac_seq_pkg::*;
#(
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned NUM_CH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            dpCtl,
  input  logic [CODE_W-1:0] codeIn,
  input  logic [NUM_CH-1:0] chanMaskN,
  input  logic              presetHigh,
  output logic              sdata,
  output logic [NUM_CH-1:0] ldN,
  output logic              presetSel
);

  localparam int unsigned PAD_W = FRAME_W - CODE_W;

  logic [FRAME_W-1:0] shiftReg;
  logic [NUM_CH-1:0]  maskReg;
  logic               presetReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      maskReg   <= '1;
      presetReg <= 1'b0;
    end else begin
      if (dpCtl.loadFrame) begin
        shiftReg <= {{PAD_W{1'b0}}, codeIn};
        maskReg  <= chanMaskN;
      end else if (dpCtl.shiftBit) begin
        shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      end
      if (dpCtl.latchPreset)
        presetReg <= presetHigh;
    end
  end

  assign sdata     = shiftReg[FRAME_W-1];
  assign presetSel = presetReg;

  // one strobe per channel, gated by the latched mask
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ld
    assign ldN[ch] = !(dpCtl.ldPhase && !maskReg[ch]);
  end

  // R8
  mask_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dpCtl.ldPhase |-> $stable(maskReg));

endmodule

// File: rtl/dac_update_seq.sv
module dac_update_seq
  import dac_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned MIN_PULSE_NS  = 40,
  parameter int unsigned MIN_DATA_NS   = 15,
  parameter int unsigned CODE_W        = 12,
  parameter int unsigned FRAME_W       = 16,
  parameter int unsigned NUM_CH        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [CODE_W-1:0] codeIn,
  input  logic [NUM_CH-1:0] chanMaskN,
  input  logic              resetReq,
  input  logic              presetHigh,
  output logic              sclk,
  output logic              sdata,
  output logic              csN,
  output logic [NUM_CH-1:0] ldN,
  output logic              rstOutN,
  output logic              presetSel,
  output logic              busy,
  output logic              done
);

  localparam int unsigned WORST_NS = (MIN_PULSE_NS > MIN_DATA_NS) ? MIN_PULSE_NS : MIN_DATA_NS;
  localparam int unsigned HALF_RAW = ceilDiv(WORST_NS, CLK_PERIOD_NS);
  localparam int unsigned HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

  dpCtl_t dpCtl;

  dac_seq_ctrl #(
    .HALF_CYC(HALF_CYC),
    .FRAME_W (FRAME_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .startReq(startReq),
    .resetReq(resetReq),
    .dpCtl   (dpCtl),
    .sclk    (sclk),
    .csN     (csN),
    .rstOutN (rstOutN),
    .busy    (busy),
    .done    (done)
  );

  dac_seq_dp #(
    .CODE_W (CODE_W),
    .FRAME_W(FRAME_W),
    .NUM_CH (NUM_CH)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .dpCtl     (dpCtl),
    .codeIn    (codeIn),
    .chanMaskN (chanMaskN),
    .presetHigh(presetHigh),
    .sdata     (sdata),
    .ldN       (ldN),
    .presetSel (presetSel)
  );

  // R3
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csN && sclk) |-> $stable(sdata));

  // R9
  preset_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rstOutN |-> $stable(presetSel));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (csN && rstOutN && (ldN == '1)));

endmodule

// File: tb/dac_update_seq_tb.sv
module dac_update_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = (40 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int NVEC = 6;
  // {code[11:0], maskN[1:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {12'hABC, 2'b10}, {12'h5A3, 2'b01}, {12'hFFF, 2'b00},
    {12'h000, 2'b11}, {12'h801, 2'b00}, {12'h7FE, 2'b10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startReq = 1'b0;
  logic [11:0] codeIn = '0;
  logic [1:0] chanMaskN = 2'b11;
  logic resetReq = 1'b0;
  logic presetHigh = 1'b0;
  logic sclk, sdata, csN, rstOutN, presetSel, busy, done;
  logic [1:0] ldN;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dac_update_seq u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .codeIn(codeIn),
    .chanMaskN(chanMaskN), .resetReq(resetReq), .presetHigh(presetHigh),
    .sclk(sclk), .sdata(sdata), .csN(csN), .ldN(ldN), .rstOutN(rstOutN),
    .presetSel(presetSel), .busy(busy), .done(done)
  );

  // protocol monitor, sampled on falling clock edges
  logic mClear = 1'b0;
  int riseCnt, csLead, csLowPre, hiRun, minHi, loRun, minLo;
  int ldRun [2];
  int ldPulses [2];
  int minLd, tailRun, rstRun, minRst, rstPulses, rstLead, csLowAny;
  logic [15:0] frameBits;
  logic dataMovedHigh, ldWhileHi, presetAtFall;
  logic pSclk, pSdata, pRst;
  logic [1:0] pLd;

  always @(negedge clk) begin
    if (mClear) begin
      mClear = 1'b0;
      riseCnt = 0; csLead = -1; csLowPre = 0; hiRun = 0; minHi = 9999;
      loRun = 0; minLo = 9999; minLd = 9999; tailRun = 0;
      rstRun = 0; minRst = 9999; rstPulses = 0; rstLead = 0; csLowAny = 0;
      for (int c = 0; c < 2; c++) begin ldRun[c] = 0; ldPulses[c] = 0; end
      frameBits = '0; dataMovedHigh = 0; ldWhileHi = 0; presetAtFall = 0;
    end else begin
      if (!csN) csLowAny++;
      if (sclk && !pSclk && !csN) begin
        if (riseCnt == 0) csLead = csLowPre;
        else if (loRun < minLo) minLo = loRun;
        loRun = 0;
        frameBits = {frameBits[14:0], sdata};
        riseCnt++;
      end
      if (!csN && !sclk && riseCnt == 0) csLowPre++;
      if (!csN && !sclk && riseCnt > 0 && riseCnt < 16) loRun++;
      if (sclk) hiRun++;
      else if (pSclk) begin
        if (hiRun < minHi) minHi = hiRun;
        hiRun = 0;
      end
      if (sclk && pSclk && sdata != pSdata) dataMovedHigh = 1;
      if (ldN != 2'b11 && sclk) ldWhileHi = 1;
      for (int c = 0; c < 2; c++) begin
        if (!ldN[c]) ldRun[c]++;
        if (!pLd[c] && ldN[c]) begin
          ldPulses[c]++;
          if (ldRun[c] < minLd) minLd = ldRun[c];
          ldRun[c] = 0;
        end
      end
      if (ldN != 2'b11) tailRun = 0;
      else if (!csN && riseCnt == 16) tailRun++;
      if (pRst && !rstOutN) begin
        rstPulses++;
        presetAtFall = presetSel;
      end
      if (busy && rstOutN && rstPulses == 0) rstLead++;
      if (!rstOutN) rstRun++;
      else if (!pRst) begin
        if (rstRun < minRst) minRst = rstRun;
        rstRun = 0;
      end
    end
    pSclk = sclk; pSdata = sdata; pRst = rstOutN; pLd = ldN;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    mClear = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitDone(output bit seen, output logic csAtDone, output logic [1:0] ldAtDone);
    seen = 0; csAtDone = 0; ldAtDone = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1; csAtDone = csN; ldAtDone = ldN;
        break;
      end
    end
  endtask

  task automatic runFrame(input logic [11:0] code, input logic [1:0] mask, input bit alsoReset);
    bit seen;
    logic csD;
    logic [1:0] ldD;
    clearMon();
    startReq = 1'b1; codeIn = code; chanMaskN = mask; resetReq = alsoReset;
    @(negedge clk);
    startReq = 1'b0; resetReq = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", busy, 1);
    waitDone(seen, csD, ldD);
    chk(seen, "R7", "done seen", seen, 1);
    chk(csD == 1'b1 && ldD == 2'b11, "R7", "lines at done", {csD, ldD}, 7);
    chk(riseCnt == 16, "R2", "rise count", riseCnt, 16);
    chk(frameBits == {4'b0000, code}, "R2", "frame bits", frameBits, {4'b0000, code});
    chk(!dataMovedHigh && minHi >= HALF && minLo >= HALF, "R3", "data/phase widths",
        (minHi < minLo) ? minHi : minLo, HALF);
    chk(csLead >= HALF, "R4", "cs lead", csLead, HALF);
    chk(ldPulses[0] == (mask[0] ? 0 : 1), "R5", "chan A pulses", ldPulses[0], mask[0] ? 0 : 1);
    chk(ldPulses[1] == (mask[1] ? 0 : 1), "R5", "chan B pulses", ldPulses[1], mask[1] ? 0 : 1);
    if (mask != 2'b11) chk(minLd >= HALF, "R5", "load width", minLd, HALF);
    chk(!ldWhileHi && tailRun >= HALF, "R6", "cs tail after load", tailRun, HALF);
    if (alsoReset) chk(rstPulses == 0, "R10", "no reset pulse", rstPulses, 0);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R7", "idle after done", {busy, done}, 0);
  endtask

  task automatic runReset(input logic lvl);
    bit seen;
    logic csD;
    logic [1:0] ldD;
    clearMon();
    resetReq = 1'b1; presetHigh = lvl;
    @(negedge clk);
    resetReq = 1'b0; presetHigh = ~lvl;
    waitDone(seen, csD, ldD);
    chk(seen, "R9", "reset done", seen, 1);
    chk(rstPulses == 1, "R9", "reset pulses", rstPulses, 1);
    chk(minRst >= HALF, "R9", "reset width", minRst, HALF);
    chk(presetAtFall == lvl, "R9", "preset at fall", presetAtFall, lvl);
    chk(rstLead >= HALF, "R9", "preset lead", rstLead, HALF);
    chk(csLowAny == 0 && riseCnt == 0, "R9", "no cs activity", csLowAny, 0);
    @(negedge clk);
    chk(presetSel == lvl, "R9", "preset kept", presetSel, lvl);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    bit seen;
    logic csD;
    logic [1:0] ldD;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csN && ldN == 2'b11 && rstOutN && !sclk && !sdata && !presetSel && !busy && !done,
        "R1", "reset outputs",
        {csN, ldN, rstOutN, sclk, sdata, presetSel, busy, done}, 9'b1_11_1_00000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      runFrame(VEC[v][13:2], VEC[v][1:0], 1'b0);

    // R8: commands during a frame are ignored
    clearMon();
    startReq = 1'b1; codeIn = 12'h3C5; chanMaskN = 2'b01;
    @(negedge clk);
    startReq = 1'b0;
    repeat (30) @(negedge clk);
    startReq = 1'b1; codeIn = 12'h999; chanMaskN = 2'b00; resetReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; resetReq = 1'b0;
    waitDone(seen, csD, ldD);
    chk(frameBits == 16'h03C5, "R8", "frame unchanged", frameBits, 16'h03C5);
    chk(ldPulses[0] == 0 && ldPulses[1] == 1, "R8", "mask unchanged",
        {ldPulses[1][0], ldPulses[0][0]}, 2);
    chk(rstPulses == 0, "R8", "reset ignored", rstPulses, 0);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && riseCnt == 16, "R8", "no later op", riseCnt, 16);

    // R10 priority of start over reset
    runFrame(12'h456, 2'b00, 1'b1);

    runReset(1'b1);
    runReset(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule